// File: doc/BRIEF.md
# T1/E1 Channel Loopback and All-Ones Steering

This block sits in one channel of a T1/E1 line interface between the system-side transmit and receive pins and the line-side transmitter and clock-recovery logic. It decides where each dual-rail stream goes. In normal operation system transmit data goes to the line and recovered line data goes to the system. On request it closes one of three test loops. The analog loop feeds the line transmit output back into the system receive side. The digital loop returns system transmit data straight to the system receive side. The remote loop sends recovered line data back out on the line. It can also replace the line output with an all-ones (AMI mark) pattern timed from the master clock.

A strap input picks the configuration source. In hardware mode one loop pin requests the analog loop. All-ones starts when the transmit clock input is held high for more than a parameterised number of master-clock cycles. In software mode separate configuration bits select each loop, force all-ones, or allow all-ones automatically on loss of signal. All logic runs on the master clock. The transmit and recovered clocks are handled as sampled level signals, and every output is registered.

Top module: `lpbk_ctrl_top`

## Requirements
- R1: While `rstN` is low, all six outputs are 0.
- R2: With no loop and no all-ones active, `lineTx{Clk,Pos,Neg}` equal `tx{Clk,Pos,Neg}` and `sysRx{Clk,Pos,Neg}` equal `rx{Clk,Pos,Neg}`, one master-clock cycle later.
- R3: In the analog loop, `sysRx*` equal the `lineTx*` output values from one cycle earlier, so `tx*` reaches `sysRx*` after two cycles and `rx*` is ignored. The loop is requested by `loopPin` in hardware mode (`swMode`=0) and by `cfgAnalog` in software mode (`swMode`=1).
- R4: In the digital loop (software mode, `cfgDigital`=1), `sysRx*` equal `tx*` one cycle later, `rx*` is ignored, and `lineTx*` still carry `tx*`.
- R5: In hardware mode every `cfg*` bit and `losIn` are ignored. In particular a digital-loop request has no effect.
- R6: In the remote loop (software mode, `cfgRemote`=1), `lineTx*` equal `rx*` one cycle later, `tx*` is ignored, and `sysRx*` still carry `rx*`.
- R7: In hardware mode only, all-ones starts on the cycle on which `txClk` has been sampled high for STUCK_LIMIT+1 (default 17) consecutive master-clock cycles. The output shows it one cycle later. A `txClk` held high in software mode never starts it.
- R8: Hardware all-ones ends on the first cycle on which `txClk` is sampled low. The high-run count clears, so a new run must again exceed STUCK_LIMIT cycles.
- R9: During all-ones the line output alternates marks. The first output cycle is (clk,pos,neg)=(0,1,0), the next is (1,0,1), and so on every master-clock cycle. `tx*` and `rx*` have no effect on the line output.
- R10: While all-ones is active a digital-loop request is suppressed, and `sysRx*` carry `rx*`.
- R11: In software mode all-ones is active when `cfgAllOnes`=1, or when `cfgAutoOnes`=1 and `losIn`=1 together. Either of the last two alone has no effect.
- R12: When several requests are set at once, all-ones wins, then remote, then analog, then digital.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master reference clock; all logic is clocked by it |
| rstN | input | 1 | Asynchronous active-low reset |
| swMode | input | 1 | 1 = configuration bits in control, 0 = pin control |
| loopPin | input | 1 | Hardware-mode loop request (analog loop) |
| cfgAnalog | input | 1 | Software analog-loop request |
| cfgDigital | input | 1 | Software digital-loop request |
| cfgRemote | input | 1 | Software remote-loop request |
| cfgAllOnes | input | 1 | Software force all-ones |
| cfgAutoOnes | input | 1 | Software permit all-ones on loss of signal |
| losIn | input | 1 | Loss-of-signal status from the receiver |
| txClk | input | 1 | System transmit clock, sampled as a level |
| txPos | input | 1 | System transmit positive rail |
| txNeg | input | 1 | System transmit negative rail |
| rxClk | input | 1 | Recovered receive clock, sampled as a level |
| rxPos | input | 1 | Recovered receive positive rail |
| rxNeg | input | 1 | Recovered receive negative rail |
| lineTxClk | output | 1 | Clock toward the line transmitter |
| lineTxPos | output | 1 | Positive rail toward the line transmitter |
| lineTxNeg | output | 1 | Negative rail toward the line transmitter |
| sysRxClk | output | 1 | Receive clock toward the system |
| sysRxPos | output | 1 | Receive positive rail toward the system |
| sysRxNeg | output | 1 | Receive negative rail toward the system |

## Verification
Several properties are checked on every cycle. Hardware mode never yields the digital steering, and all-ones never coexists with it. A low transmit clock in hardware mode always drops all-ones. Marks alternate between rails while all-ones is held. The remote and analog paths deliver the value they were tapped from one cycle before. The exact length of the high run that starts all-ones can only be shown by the bench's scenarios, and so can the clearing of the run on a low sample and the resolution of conflicting bits. The same holds for loss-of-signal gating and for inputs having no effect during each loop, which the bench exposes by driving changing data on the ignored side.

// File: rtl/lpbk_pkg.sv
`timescale 1ns/1ps
package lpbk_pkg;
  typedef enum logic [1:0] {
    LINE_FROM_SYS   = 2'd0,
    LINE_FROM_RECOV = 2'd1,
    LINE_FROM_ONES  = 2'd2
  } lineSrc_e;

  typedef enum logic [1:0] {
    SYS_FROM_LINEIN  = 2'd0,
    SYS_FROM_TX      = 2'd1,
    SYS_FROM_LINEOUT = 2'd2
  } sysSrc_e;

  typedef struct packed {
    lineSrc_e lineSrc;
    sysSrc_e  sysSrc;
  } steer_t;

  typedef struct packed {
    logic clk;
    logic pos;
    logic neg;
  } rail_t;
endpackage

// File: rtl/lpbk_stuck_det.sv
`timescale 1ns/1ps
module lpbk_stuck_det #(
  parameter int STUCK_LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic level,
  output logic stuck
);
  localparam int CW = $clog2(STUCK_LIMIT + 1);
  localparam logic [CW-1:0] SAT = CW'(STUCK_LIMIT);

  logic [CW-1:0] runCnt;

  // Count consecutive high samples; saturate, clear on any low sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            runCnt <= '0;
    else if (!level)      runCnt <= '0;
    else if (runCnt != SAT) runCnt <= runCnt + 1'b1;
  end

  // The current sample is the (STUCK_LIMIT+1)-th high one or later.
  assign stuck = level && (runCnt == SAT);
endmodule

// File: rtl/lpbk_ctrl.sv
`timescale 1ns/1ps
module lpbk_ctrl
  import lpbk_pkg::*;
#(
  parameter int STUCK_LIMIT = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   swMode,
  input  logic   loopPin,
  input  logic   cfgAnalog,
  input  logic   cfgDigital,
  input  logic   cfgRemote,
  input  logic   cfgAllOnes,
  input  logic   cfgAutoOnes,
  input  logic   losIn,
  input  logic   txClk,
  output steer_t steer
);
  logic hwStuck;
  logic onesReq, remoteReq, analogReq, digitalReq;

  lpbk_stuck_det #(.STUCK_LIMIT(STUCK_LIMIT)) stuck_i (
    .clk  (clk),
    .rstN (rstN),
    .level(txClk),
    .stuck(hwStuck)
  );

  always_comb begin
    onesReq    = swMode ? (cfgAllOnes | (cfgAutoOnes & losIn)) : hwStuck;
    remoteReq  = swMode & cfgRemote;
    analogReq  = swMode ? cfgAnalog : loopPin;
    digitalReq = swMode & cfgDigital & ~onesReq;
  end

  // Fixed priority: all-ones, remote, analog, digital.
  always_comb begin
    steer.lineSrc = LINE_FROM_SYS;
    steer.sysSrc  = SYS_FROM_LINEIN;
    if (onesReq) begin
      steer.lineSrc = LINE_FROM_ONES;
    end else if (remoteReq) begin
      steer.lineSrc = LINE_FROM_RECOV;
    end else if (analogReq) begin
      steer.sysSrc  = SYS_FROM_LINEOUT;
    end else if (digitalReq) begin
      steer.sysSrc  = SYS_FROM_TX;
    end
  end
endmodule

// File: rtl/lpbk_datapath.sv
`timescale 1ns/1ps
module lpbk_datapath
  import lpbk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  steer_t steer,
  input  rail_t  txIn,
  input  rail_t  rxIn,
  output rail_t  lineOut,
  output rail_t  sysOut
);
  logic  markPhase;
  rail_t lineNext;
  rail_t sysNext;

  always_comb begin
    case (steer.lineSrc)
      LINE_FROM_RECOV: lineNext = rxIn;
      LINE_FROM_ONES:  lineNext = '{clk: markPhase, pos: ~markPhase, neg: markPhase};
      default:         lineNext = txIn;
    endcase
  end

  always_comb begin
    case (steer.sysSrc)
      SYS_FROM_TX:      sysNext = txIn;
      SYS_FROM_LINEOUT: sysNext = lineOut;
      default:          sysNext = rxIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markPhase <= 1'b0;
      lineOut   <= '0;
      sysOut    <= '0;
    end else begin
      markPhase <= (steer.lineSrc == LINE_FROM_ONES) ? ~markPhase : 1'b0;
      lineOut   <= lineNext;
      sysOut    <= sysNext;
    end
  end
endmodule

// File: rtl/lpbk_ctrl_top.sv
`timescale 1ns/1ps
module lpbk_ctrl_top
  import lpbk_pkg::*;
#(
  parameter int STUCK_LIMIT = 16
) (
  input  logic mclk,
  input  logic rstN,
  input  logic swMode,
  input  logic loopPin,
  input  logic cfgAnalog,
  input  logic cfgDigital,
  input  logic cfgRemote,
  input  logic cfgAllOnes,
  input  logic cfgAutoOnes,
  input  logic losIn,
  input  logic txClk,
  input  logic txPos,
  input  logic txNeg,
  input  logic rxClk,
  input  logic rxPos,
  input  logic rxNeg,
  output logic lineTxClk,
  output logic lineTxPos,
  output logic lineTxNeg,
  output logic sysRxClk,
  output logic sysRxPos,
  output logic sysRxNeg
);
  steer_t steerBus;
  rail_t  txRail, rxRail, lineRail, sysRail;

  assign txRail = '{clk: txClk, pos: txPos, neg: txNeg};
  assign rxRail = '{clk: rxClk, pos: rxPos, neg: rxNeg};

  lpbk_ctrl #(.STUCK_LIMIT(STUCK_LIMIT)) ctrl_i (
    .clk        (mclk),
    .rstN       (rstN),
    .swMode     (swMode),
    .loopPin    (loopPin),
    .cfgAnalog  (cfgAnalog),
    .cfgDigital (cfgDigital),
    .cfgRemote  (cfgRemote),
    .cfgAllOnes (cfgAllOnes),
    .cfgAutoOnes(cfgAutoOnes),
    .losIn      (losIn),
    .txClk      (txClk),
    .steer      (steerBus)
  );

  lpbk_datapath dp_i (
    .clk    (mclk),
    .rstN   (rstN),
    .steer  (steerBus),
    .txIn   (txRail),
    .rxIn   (rxRail),
    .lineOut(lineRail),
    .sysOut (sysRail)
  );

  assign lineTxClk = lineRail.clk;
  assign lineTxPos = lineRail.pos;
  assign lineTxNeg = lineRail.neg;
  assign sysRxClk  = sysRail.clk;
  assign sysRxPos  = sysRail.pos;
  assign sysRxNeg  = sysRail.neg;
endmodule

// File: rtl/lpbk_ctrl_top_chk.sv
`timescale 1ns/1ps
module lpbk_ctrl_top_chk
  import lpbk_pkg::*;
(
  input logic   mclk,
  input logic   rstN,
  input logic   swMode,
  input logic   txClk,
  input logic   rxClk,
  input logic   rxPos,
  input logic   rxNeg,
  input logic   lineTxClk,
  input logic   lineTxPos,
  input logic   lineTxNeg,
  input logic   sysRxPos,
  input steer_t steerBus
);
  logic [1:0] age;
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5
  hw_no_digital_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !swMode |-> steerBus.sysSrc != SYS_FROM_TX);

  // R10
  ones_blocks_digital_chk: assert property (@(posedge mclk) disable iff (!rstN)
    steerBus.lineSrc == LINE_FROM_ONES |-> steerBus.sysSrc != SYS_FROM_TX);

  // R8
  hw_low_exit_chk: assert property (@(posedge mclk) disable iff (!rstN)
    (!swMode && !txClk) |-> steerBus.lineSrc != LINE_FROM_ONES);

  // R9
  ami_alternate_chk: assert property (@(posedge mclk) disable iff (!rstN)
    (age == 2'd3 && $past(steerBus.lineSrc == LINE_FROM_ONES)
                 && $past(steerBus.lineSrc == LINE_FROM_ONES, 2))
    |-> (lineTxPos != $past(lineTxPos)) && (lineTxPos != lineTxNeg));

  // R6
  remote_path_chk: assert property (@(posedge mclk) disable iff (!rstN)
    (age != 2'd0 && $past(steerBus.lineSrc == LINE_FROM_RECOV))
    |-> lineTxPos == $past(rxPos) && lineTxNeg == $past(rxNeg) && lineTxClk == $past(rxClk));

  // R3
  analog_path_chk: assert property (@(posedge mclk) disable iff (!rstN)
    (age >= 2'd2 && $past(steerBus.sysSrc == SYS_FROM_LINEOUT))
    |-> sysRxPos == $past(lineTxPos));
endmodule

bind lpbk_ctrl_top lpbk_ctrl_top_chk chk_i (
  .mclk     (mclk),
  .rstN     (rstN),
  .swMode   (swMode),
  .txClk    (txClk),
  .rxClk    (rxClk),
  .rxPos    (rxPos),
  .rxNeg    (rxNeg),
  .lineTxClk(lineTxClk),
  .lineTxPos(lineTxPos),
  .lineTxNeg(lineTxNeg),
  .sysRxPos (sysRxPos),
  .steerBus (steerBus)
);

// File: tb/lpbk_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module lpbk_ctrl_top_tb_top;
  localparam int LIMIT = 16;

  logic mclk = 1'b0;
  logic rstN = 1'b0;
  logic swMode = 0, loopPin = 0, cfgAnalog = 0, cfgDigital = 0, cfgRemote = 0;
  logic cfgAllOnes = 0, cfgAutoOnes = 0, losIn = 0;
  logic txClk = 0, txPos = 0, txNeg = 0, rxClk = 0, rxPos = 0, rxNeg = 0;
  logic lineTxClk, lineTxPos, lineTxNeg, sysRxClk, sysRxPos, sysRxNeg;

  always #2 mclk = ~mclk;

  lpbk_ctrl_top #(.STUCK_LIMIT(LIMIT)) dut_i (
    .mclk(mclk), .rstN(rstN), .swMode(swMode), .loopPin(loopPin),
    .cfgAnalog(cfgAnalog), .cfgDigital(cfgDigital), .cfgRemote(cfgRemote),
    .cfgAllOnes(cfgAllOnes), .cfgAutoOnes(cfgAutoOnes), .losIn(losIn),
    .txClk(txClk), .txPos(txPos), .txNeg(txNeg),
    .rxClk(rxClk), .rxPos(rxPos), .rxNeg(rxNeg),
    .lineTxClk(lineTxClk), .lineTxPos(lineTxPos), .lineTxNeg(lineTxNeg),
    .sysRxClk(sysRxClk), .sysRxPos(sysRxPos), .sysRxNeg(sysRxNeg)
  );

  typedef struct {
    logic [2:0] line;
    logic [2:0] sys;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state built from the requirements
  int         mRun = 0;
  logic       mPhase = 0;
  logic [2:0] mLine = 3'b000;

  // cfg = {sw, loopPin, analog, digital, remote, allOnes, autoOnes, los}
  task automatic drive(input logic [7:0] cfg, input logic [2:0] tx,
                       input logic [2:0] rx, input string tag);
    logic sw, ones, hwStuck;
    logic [2:0] lineE, sysE;
    @(negedge mclk);
    {swMode, loopPin, cfgAnalog, cfgDigital, cfgRemote, cfgAllOnes, cfgAutoOnes, losIn} = cfg;
    {txClk, txPos, txNeg} = tx;
    {rxClk, rxPos, rxNeg} = rx;
    sw = cfg[7];
    hwStuck = tx[2] && (mRun >= LIMIT);
    mRun = tx[2] ? ((mRun < LIMIT) ? mRun + 1 : mRun) : 0;
    ones = sw ? (cfg[2] | (cfg[1] & cfg[0])) : hwStuck;
    sysE = rx;
    if (ones) begin
      lineE = {mPhase, ~mPhase, mPhase};
      mPhase = ~mPhase;
    end else begin
      mPhase = 1'b0;
      if (sw && cfg[3]) lineE = rx;
      else begin
        lineE = tx;
        if (sw ? cfg[5] : cfg[6]) sysE = mLine;
        else if (sw && cfg[4]) sysE = tx;
      end
    end
    mLine = lineE;
    expQ.push_back('{line: lineE, sys: sysE, tag: tag});
  endtask

  // Monitor: compare one expected item per clock, 1 ns after the edge
  always @(posedge mclk) begin
    #1;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checks++;
      if ({lineTxClk, lineTxPos, lineTxNeg} !== cur.line ||
          {sysRxClk, sysRxPos, sysRxNeg} !== cur.sys) begin
        errors++;
        $display("FAIL %s line=%b sys=%b expected line=%b sys=%b", cur.tag,
                 {lineTxClk, lineTxPos, lineTxNeg}, {sysRxClk, sysRxPos, sysRxNeg},
                 cur.line, cur.sys);
      end
    end
  end

  function automatic logic [2:0] rnd3();
    return 3'($urandom_range(0, 7));
  endfunction

  task automatic flush();
    while (expQ.size() > 0) @(negedge mclk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: outputs stay zero under reset despite active inputs
    {rxClk, rxPos, rxNeg} = 3'b111;
    txPos = 1; txNeg = 1;
    repeat (3) @(posedge mclk);
    #1;
    checks++;
    if ({lineTxClk, lineTxPos, lineTxNeg, sysRxClk, sysRxPos, sysRxNeg} !== 6'b0) begin
      errors++;
      $display("FAIL R1 outs=%b expected 000000",
               {lineTxClk, lineTxPos, lineTxNeg, sysRxClk, sysRxPos, sysRxNeg});
    end
    @(negedge mclk);
    rstN = 1'b1;

    for (int i = 0; i < 8; i++) drive(8'b0000_0000, rnd3() & 3'b011, rnd3(), "R2 hw normal");
    for (int i = 0; i < 8; i++) drive(8'b1000_0000, rnd3(), rnd3(), "R2 sw normal");
    for (int i = 0; i < 8; i++) drive(8'b0100_0000, rnd3() & 3'b011, rnd3(), "R3 hw analog");
    for (int i = 0; i < 8; i++) drive(8'b1010_0000, rnd3(), rnd3(), "R3 sw analog");
    for (int i = 0; i < 8; i++) drive(8'b1001_0000, rnd3(), rnd3(), "R4 digital");
    for (int i = 0; i < 6; i++) drive(8'b0001_0000, rnd3() & 3'b011, rnd3(), "R5 hw digital ignored");
    for (int i = 0; i < 6; i++) drive(8'b0011_1111, rnd3() & 3'b011, rnd3(), "R5 hw cfg ignored");
    for (int i = 0; i < 8; i++) drive(8'b1000_1000, rnd3(), rnd3(), "R6 remote");

    // R7/R8: hardware stuck-high run; 17th high sample starts all-ones
    drive(8'b0000_0000, 3'b000, rnd3(), "R7 prep");
    for (int i = 0; i < 40; i++) drive(8'b0000_0000, 3'b100 | (rnd3() & 3'b011), rnd3(), "R7 hw stuck high");
    drive(8'b0000_0000, 3'b011, rnd3(), "R8 exit on low");
    for (int i = 0; i < 10; i++) drive(8'b0000_0000, 3'b100 | (rnd3() & 3'b011), rnd3(), "R8 run restarts");
    drive(8'b0000_0000, 3'b000, rnd3(), "R8 low again");
    for (int i = 0; i < 24; i++) drive(8'b1000_0000, 3'b100 | (rnd3() & 3'b011), rnd3(), "R7 sw no stuck ones");

    for (int i = 0; i < 8; i++) drive(8'b1000_0100, rnd3(), rnd3(), "R9 ami pattern");
    drive(8'b1000_0000, rnd3(), rnd3(), "R9 leave ones");
    for (int i = 0; i < 6; i++) drive(8'b1001_0100, rnd3(), rnd3(), "R10 digital blocked");

    for (int i = 0; i < 5; i++) drive(8'b1000_0011, rnd3(), rnd3(), "R11 auto on los");
    for (int i = 0; i < 4; i++) drive(8'b1000_0010, rnd3(), rnd3(), "R11 auto no los");
    for (int i = 0; i < 4; i++) drive(8'b1000_0001, rnd3(), rnd3(), "R11 los no auto");

    for (int i = 0; i < 5; i++) drive(8'b1010_1000, rnd3(), rnd3(), "R12 remote over analog");
    for (int i = 0; i < 5; i++) drive(8'b1011_1100, rnd3(), rnd3(), "R12 ones over all");
    for (int i = 0; i < 5; i++) drive(8'b1011_0000, rnd3(), rnd3(), "R12 analog over digital");
    for (int i = 0; i < 5; i++) drive(8'b1001_1000, rnd3(), rnd3(), "R12 remote over digital");
    drive(8'b0100_0000, 3'b000, rnd3(), "R12 hw prep");
    for (int i = 0; i < 22; i++) drive(8'b0100_0000, 3'b100 | (rnd3() & 3'b011), rnd3(), "R12 hw ones over analog");
    drive(8'b0100_0000, 3'b001, rnd3(), "R12 hw back to analog");
    drive(8'b0100_0000, 3'b010, rnd3(), "R12 hw analog");

    flush();
    @(negedge mclk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule